// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external host read and write a bank of 128 eight-bit registers over a four-wire SPI link: serial clock, host-to-slave data, slave-to-host data and an active-low select. Each access is one 16-bit frame. The frame carries a 7-bit register address, then one direction bit, then one data byte. A write frame stores the byte in the addressed register. A read frame returns the addressed register to the host on the data-out line. The data-out driver is enabled only while that byte is being sent.

The link pins are treated as plain inputs that are already synchronous to the block clock `clk`. The block finds the edges of the serial clock by comparing each sample with the one before it. Each level of the serial clock must therefore be held for at least two `clk` cycles. Inputs are taken on the detected rising edges and the output changes on the detected falling edges, which is SPI mode 0. The output enable is a separate port, `spi_miso_oe`, so an I/O cell or a test can see when the line is released.

The data pins carry no valid/ready handshake. The pace is set entirely by the host's serial clock. There is no back-pressure: the register bank accepts a write on any frame and always has read data ready.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset is asserted, every register reads as 0x00 and `spi_miso_oe` is 0.
- R2: A frame whose direction bit is 1 writes the data byte into the addressed register. The write takes effect only on the 16th rising serial-clock edge of the frame.
- R3: A frame whose direction bit is 0 returns the addressed register's value most-significant bit first. One bit is driven per falling edge, and the first bit is valid before the 9th rising edge. A read leaves the register unchanged, and the data bits the host sends during a read are ignored.
- R4: The frame layout is fixed. Bits 1 to 7 (first in time) are the address, most-significant bit first. Bit 8 is the direction bit. Bits 9 to 16 are the data byte, most-significant bit first. Input bits are taken on rising serial-clock edges.
- R5: `spi_miso_oe` is 1 only in a read frame. It rises at the falling edge after bit 8 and drops at the falling edge after bit 16. It is 0 during write frames, during the address phase and whenever select is high.
- R6: While `spi_cs_n` is high, the bit position is held at the start of a frame. A frame cut short by raising select changes no register, and the next frame starts again at bit 1.
- R7: Serial-clock edges after the 16th within one select-low period are ignored until select is raised. They change no register and do not enable the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all SPI pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso`; 0 means high impedance |

## Verification
The assertions check several rules on every cycle. The output enable must drop and the bit position must clear once select is high. The enable must never be on during a write frame. A register write may happen only at the final bit, and no bit can be counted after the frame completes. The returned bit must hold steady between falling edges. Other behaviour needs the bench's scenarios to show it: that the right byte lands at the right address, that reads return it MSB first, that aborted frames leave the bank untouched, and that clocks past the 16th do nothing. These need whole frames driven from the host side and the results read back.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = ADDR_W + 1 + DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam int unsigned DEPTH      = 1 << ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              is_write;
  } frame_hdr_t;
endpackage

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = !cs_n &&  sclk && !sclk_q;
  assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_reg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned NB = AW + 1 + DW,
  localparam int unsigned CW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rise,
  input  logic          mosi,
  output logic [CW-1:0] bit_cnt,
  output logic          done,
  output logic          is_write,
  output logic          rd_stb,
  output logic [AW-1:0] rd_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam logic [CW-1:0] HDR_LAST   = CW'(AW);
  localparam logic [CW-1:0] FRAME_LAST = CW'(NB - 1);

  logic [NB-2:0] shreg;
  frame_hdr_t    hdr;
  logic          take;

  assign take    = rise && !done;
  assign rd_addr = shreg[AW-1:0];
  assign rd_stb  = take && (bit_cnt == HDR_LAST) && !mosi;
  assign wr_stb  = take && (bit_cnt == FRAME_LAST) && hdr.is_write;
  assign wr_addr = hdr.addr;
  assign wr_data = {shreg[DW-2:0], mosi};
  assign is_write = hdr.is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      done    <= 1'b0;
      shreg   <= '0;
      hdr     <= '0;
    end else if (cs_n) begin
      bit_cnt <= '0;
      done    <= 1'b0;
      shreg   <= '0;
      hdr     <= '0;
    end else if (take) begin
      shreg <= {shreg[NB-3:0], mosi};
      if (bit_cnt == HDR_LAST) begin
        hdr.addr     <= shreg[AW-1:0];
        hdr.is_write <= mosi;
      end
      if (bit_cnt == FRAME_LAST) begin
        done <= 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array
  import spi_reg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [N];

  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cells[g] <= '0;
      else if (we && waddr == AW'(g))     cells[g] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          fall,
  input  logic          done,
  output logic          miso,
  output logic          miso_oe
);
  logic [DW-1:0] txreg;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg   <= '0;
      armed   <= 1'b0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (cs_n) begin
      txreg   <= '0;
      armed   <= 1'b0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (load) begin
      txreg <= load_data;
      armed <= 1'b1;
    end else if (fall) begin
      if (done) begin
        miso_oe <= 1'b0;
        miso    <= 1'b0;
      end else if (armed || miso_oe) begin
        miso    <= txreg[DW-1];
        txreg   <= {txreg[DW-2:0], 1'b0};
        miso_oe <= 1'b1;
        armed   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned NB = AW + 1 + DW,
  localparam int unsigned CW = $clog2(NB)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic          rise, fall;
  logic [CW-1:0] bit_cnt;
  logic          done, is_write, rd_stb, wr_stb;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data, rd_data;

  spi_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (spi_sclk),
    .cs_n (spi_cs_n),
    .rise (rise),
    .fall (fall)
  );

  spi_frame_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .rise    (rise),
    .mosi    (spi_mosi),
    .bit_cnt (bit_cnt),
    .done    (done),
    .is_write(is_write),
    .rd_stb  (rd_stb),
    .rd_addr (rd_addr),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  spi_reg_array #(.AW(AW), .DW(DW)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_stb),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  spi_tx_shift #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .load     (rd_stb),
    .load_data(rd_data),
    .fall     (fall),
    .done     (done),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          miso,
  input logic          miso_oe,
  input logic [CW-1:0] bit_cnt,
  input logic          done,
  input logic          is_write,
  input logic          wr_stb,
  input logic          fall
);
  // R5: deselect releases the data-out line
  a_r5_oe_off_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !miso_oe);

  // R5: the line is never driven during a write frame
  a_r5_oe_not_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !is_write);

  // R6: deselect returns the frame to bit 1
  a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0 && !done));

  // R7: a finished frame counts no further bits
  a_r7_cnt_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cs_n) |=> $stable(bit_cnt));

  // R2: a register write closes the frame
  a_r2_write_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> done);

  // R3: the returned bit only moves on a falling edge
  a_r3_miso_holds_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !fall && !cs_n) |=> $stable(miso));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (spi_cs_n),
  .miso    (spi_miso),
  .miso_oe (spi_miso_oe),
  .bit_cnt (bit_cnt),
  .done    (done),
  .is_write(is_write),
  .wr_stb  (wr_stb),
  .fall    (fall)
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  localparam int HALF = 4;
  localparam int NVEC = 14;
  // {is_write, addr[6:0], data[7:0], expected[7:0]}
  localparam logic [23:0] VECS [NVEC] = '{
    {1'b1, 7'h00, 8'hA5, 8'h00},
    {1'b1, 7'h7F, 8'h3C, 8'h00},
    {1'b1, 7'h55, 8'h81, 8'h00},
    {1'b1, 7'h2A, 8'h7E, 8'h00},
    {1'b0, 7'h00, 8'h00, 8'hA5},
    {1'b0, 7'h7F, 8'h00, 8'h3C},
    {1'b0, 7'h55, 8'h00, 8'h81},
    {1'b0, 7'h2A, 8'h00, 8'h7E},
    {1'b0, 7'h01, 8'h00, 8'h00},
    {1'b0, 7'h55, 8'hFF, 8'h81},
    {1'b0, 7'h55, 8'h00, 8'h81},
    {1'b1, 7'h7F, 8'hFF, 8'h00},
    {1'b0, 7'h7F, 8'h00, 8'hFF},
    {1'b0, 7'h00, 8'h5A, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  spi_reg_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sclk   (sclk),
    .spi_cs_n   (cs_n),
    .spi_mosi   (mosi),
    .spi_miso   (miso),
    .spi_miso_oe(miso_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives nbits serial-clock pulses; bits past 16 send a 1 on mosi.
  task automatic frame(input logic [15:0] w, input int nbits,
                       output logic [7:0] got, output int oe_bad);
    logic rd;
    rd = !w[8];
    got = '0;
    oe_bad = 0;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 1; i <= nbits; i++) begin
      mosi = (i <= 16) ? w[16-i] : 1'b1;
      wait_clk(HALF);
      if (miso_oe !== (rd && i >= 9 && i <= 16)) oe_bad++;
      if (i >= 9 && i <= 16) got[16-i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    if (miso_oe !== 1'b0) oe_bad++;
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2);
    if (miso_oe !== 1'b0) oe_bad++;
    wait_clk(2 * HALF);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input int nbits,
                          input string req);
    logic [7:0] g;
    int ob;
    frame({a, 1'b1, d}, nbits, g, ob);
    check(req, ob, 0);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input int nbits,
                         input string req);
    logic [7:0] g;
    int ob;
    frame({a, 1'b0, 8'h00}, nbits, g, ob);
    check({req, " data"}, int'(g), int'(exp));
    check({req, " oe window"}, ob, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    check("R1 oe in reset", int'(miso_oe), 0);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1 oe after reset", int'(miso_oe), 0);
    do_read(7'h10, 8'h00, 16, "R1 register cleared");

    // Vector walk: R2 writes, R3 reads, R4 layout over varied addresses
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] g;
      int ob;
      frame({VECS[v][22:16], VECS[v][23], VECS[v][15:8]}, 16, g, ob);
      check($sformatf("R5 vec %0d oe window", v), ob, 0);
      if (!VECS[v][23])
        check($sformatf("R3/R4 vec %0d read", v), int'(g), int'(VECS[v][7:0]));
    end

    // R6: aborted writes change nothing
    do_write(7'h10, 8'h99, 12, "R6 abort at 12 oe");
    do_read(7'h10, 8'h00, 16, "R6 after abort at 12");
    do_write(7'h10, 8'h99, 15, "R6 abort at 15 oe");
    do_read(7'h10, 8'h00, 16, "R6 after abort at 15");
    do_write(7'h10, 8'h5A, 16, "R6 fresh frame oe");
    do_read(7'h10, 8'h5A, 16, "R6 full write after aborts");
    // aborted read leaves line released
    do_read(7'h10, 8'h00, 4, "R6 aborted read");
    do_read(7'h10, 8'h5A, 16, "R6 read after aborted read");

    // R7: extra clocks ignored
    do_write(7'h11, 8'h33, 20, "R7 write with extra clocks oe");
    do_read(7'h11, 8'h33, 16, "R7 write landed");
    do_read(7'h7F, 8'hFF, 16, "R7 no stray write to 7F");
    do_read(7'h11, 8'h33, 21, "R7 read with extra clocks");
    do_read(7'h00, 8'hA5, 16, "R7 reg 00 untouched");

    // R1: reset clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(3);
    check("R1 oe during second reset", int'(miso_oe), 0);
    rst_n = 1'b1;
    wait_clk(3);
    do_read(7'h55, 8'h00, 16, "R1 cleared after reset");
    do_read(7'h11, 8'h00, 16, "R1 second cleared after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule